// File: doc/BRIEF.md
# SPI Card Host Port

This block is a memory-mapped SPI master for a memory card or a serial flash, attached to a small 8-bit register bus. It has one data register that does two jobs. A write to it starts a full-duplex 8-bit transfer of the written byte. A read returns the byte that the most recent completed transfer received. Software therefore reads first and then writes the next byte. The serial clock runs in SPI mode 0, with the most significant bit first. Its rate is the system clock divided by a fixed parameter.

Chip selection is not tied to transfers. A separate select register drives the levels of three chip-select lines (memory card, serial flash, front panel) and an active-low user LED. Software frames a card command by writing this register around a burst of data-register accesses. A status register shows the busy state and a synchronised card-detect input. A read-only version register returns a constant identifier.

Top module: `spi_card_port`

## Requirements
- R1: After synchronous active-low reset, all of the following hold: the data register reads 0x00; the select register reads 0x00, so every chip-select pin and led_n are low; the status register reads 0x00; spi_sclk is low.
- R2: A write to offset 0 while idle starts a transfer. It sends the written byte on spi_mosi, MSB first, in SPI mode 0. Each bit is valid before its rising spi_sclk edge and changes only after the falling edge.
- R3: spi_sclk is low when idle. While busy it toggles every CLK_HALF_DIV system clocks, beginning low. A transfer lasts exactly 16*CLK_HALF_DIV cycles after the accepting clock edge.
- R4: spi_miso is sampled on each rising spi_sclk edge, MSB first. The received byte is readable at offset 0 once the transfer ends. It keeps that value until the next transfer ends.
- R5: Status bit 0 (offset 2) reads 1 from the clock after an accepted write until the transfer ends, and 0 otherwise.
- R6: A write to offset 0 while busy is ignored. The bits on spi_mosi, the transfer length and the received byte are unchanged.
- R7: Select register (offset 1). Bit 0 drives card_cs, bit 1 drives flash_cs, bit 2 drives panel_cs and bit 3 drives led_n (0 lights the LED). A write takes effect on the next clock, including during a transfer. Bits 7:4 read 0.
- R8: Status bit 1 shows card_detect after a two-register synchronizer. A change is visible in a read two clocks after it is applied.
- R9: Offset 3 always reads 0x31. Writes to offsets 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| card_cs | output | 1 | Memory card chip-select level |
| flash_cs | output | 1 | Serial flash chip-select level |
| panel_cs | output | 1 | Front panel chip-select level |
| led_n | output | 1 | User LED, lit when low |
| card_detect | input | 1 | Card presence input, asynchronous |

## Verification
A wrong divider count or edge counter shows up on spi_sclk within one half period of the accepting edge. A slip in the shift register shows up as a wrong spi_mosi level before the next rising edge. A busy flag that drops early, or a write that restarts a transfer, changes the spi_sclk pattern on the very next cycle. The cycle-by-cycle model therefore catches it at once. Receive-path errors surface only when the data register is read after the transfer ends. Select-register faults appear on the pins one clock after the write.

// File: rtl/spi_port_pkg.sv
// Shared register offsets and bit positions for the SPI card host port.
// Assumes a 2-bit register offset on the host bus.
package spi_port_pkg;

    typedef enum logic [1:0] {
        REG_DATA    = 2'd0,
        REG_SELECT  = 2'd1,
        REG_STATUS  = 2'd2,
        REG_VERSION = 2'd3
    } reg_addr_e;

    localparam int SEL_W     = 4;
    localparam int SEL_CARD  = 0;
    localparam int SEL_FLASH = 1;
    localparam int SEL_PANEL = 2;
    localparam int SEL_LED_N = 3;

    localparam int STAT_BUSY = 0;
    localparam int STAT_CD   = 1;

endpackage

// File: rtl/spi_sync2.sv
// Two-register synchronizer for asynchronous level inputs.
// Assumes the input is a slowly changing level; no pulse capture.
module spi_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Move the input through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/spi_select_reg.sv
// Select register: holds chip-select levels and the LED bit.
// Assumes wr is a single-cycle strobe already decoded for this register.
module spi_select_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] sel_q;

    // Load the written bits; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  sel_q <= '0;
        else if (wr) sel_q <= wdata;
    end

    assign q = sel_q;

    // R7: a write lands on the next clock
    a_r7_select_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q == $past(wdata)));

    // R7: without a write the pins hold
    a_r7_select_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));

endmodule

// File: rtl/spi_byte_engine.sv
// Full-duplex SPI mode 0 shift engine, MSB first.
// Assumes start is a one-cycle strobe; a start while busy is dropped.
// SCLK half period is HALF_DIV system clocks; the received byte is
// published only when the last falling edge completes.
module spi_byte_engine #(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int EDGES  = 2 * DATA_W;
    localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGES - 1);

    logic              busy_q;
    logic              sclk_q;
    logic [DIV_W-1:0]  div_q;
    logic [EDGE_W-1:0] edge_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_q;
    logic              half_done;
    logic              finish;

    assign half_done = busy_q && (div_q == DIV_LAST);
    assign finish    = half_done && sclk_q && (edge_q == EDGE_LAST);

    // Accept a start when idle, then step the clock and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            div_q  <= '0;
            edge_q <= '0;
            tx_q   <= '0;
            rx_sh  <= '0;
            rx_q   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                tx_q   <= tx_byte;
                div_q  <= '0;
                edge_q <= '0;
                sclk_q <= 1'b0;
            end
        end else if (half_done) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (!sclk_q) begin
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end else if (edge_q == EDGE_LAST) begin
                busy_q <= 1'b0;
                rx_q   <= rx_sh;
            end else begin
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            end
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign busy    = busy_q;
    assign sclk    = sclk_q;
    assign mosi    = tx_q[DATA_W-1];
    assign rx_byte = rx_q;

    // Length of the current busy run, for the transfer-length check.
    int unsigned run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)       run_len <= 0;
        else if (!busy_q) run_len <= 0;
        else              run_len <= run_len + 1;
    end

    // R3: the serial clock rests low when idle
    a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);

    // R3: each transfer spans 2*DATA_W half periods
    a_r3_transfer_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (run_len == EDGES * HALF_DIV));

    // R2: data is steady across each rising edge
    a_r2_mosi_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(mosi));

    // R6: a start while busy neither ends nor rewinds the transfer
    a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && !finish) |=>
            (busy_q && (edge_q == $past(edge_q) || edge_q == $past(edge_q) + EDGE_W'(1))));

    // R4: the received byte changes only at the end of a transfer
    a_r4_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(rx_q));

endmodule

// File: rtl/spi_card_port.sv
// SPI card host port top: register decode, byte engine, select
// register and card-detect synchronizer.
// Assumes a single-cycle write strobe and a combinational read path.
module spi_card_port
    import spi_port_pkg::*;
#(
    parameter int          CLK_HALF_DIV = 4,
    parameter logic [7:0]  VERSION_ID   = 8'h31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       card_cs,
    output logic       flash_cs,
    output logic       panel_cs,
    output logic       led_n,
    input  logic       card_detect
);

    localparam int DATA_W = 8;

    logic              wr_data;
    logic              wr_sel;
    logic              busy;
    logic [DATA_W-1:0] rx_byte;
    logic [SEL_W-1:0]  sel_q;
    logic              cd_sync;

    // Decode writes per register offset.
    always_comb begin
        wr_data = bus_wr && (reg_addr_e'(bus_addr) == REG_DATA);
        wr_sel  = bus_wr && (reg_addr_e'(bus_addr) == REG_SELECT);
    end

    spi_byte_engine #(
        .DATA_W   (DATA_W),
        .HALF_DIV (CLK_HALF_DIV)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_data),
        .tx_byte (bus_wdata),
        .miso    (spi_miso),
        .busy    (busy),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .rx_byte (rx_byte)
    );

    spi_select_reg #(
        .W (SEL_W)
    ) u_select (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_sel),
        .wdata (bus_wdata[SEL_W-1:0]),
        .q     (sel_q)
    );

    spi_sync2 #(
        .W (1)
    ) u_cd_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (card_detect),
        .sync_out (cd_sync)
    );

    assign card_cs  = sel_q[SEL_CARD];
    assign flash_cs = sel_q[SEL_FLASH];
    assign panel_cs = sel_q[SEL_PANEL];
    assign led_n    = sel_q[SEL_LED_N];

    // Select the read value for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            REG_DATA:    bus_rdata = rx_byte;
            REG_SELECT:  bus_rdata[SEL_W-1:0] = sel_q;
            REG_STATUS: begin
                bus_rdata[STAT_BUSY] = busy;
                bus_rdata[STAT_CD]   = cd_sync;
            end
            default:     bus_rdata = VERSION_ID;
        endcase
    end

    // R9: the version offset never changes, whatever is written
    a_r9_version_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_e'(bus_addr) == REG_VERSION) |-> (bus_rdata == VERSION_ID));

    // R5: busy rises only after a data write
    a_r5_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_data));

endmodule

// File: tb/tb_spi_card_port.sv
// Bench: behavioural reference model compared on every clock, plus
// a mode-0 slave that answers with a chosen byte.
module tb_spi_card_port;

    localparam int HALF = 4;
    localparam int XFER = 16 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_mosi, spi_miso;
    logic       card_cs, flash_cs, panel_cs, led_n;
    logic       card_detect = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_card_port #(.CLK_HALF_DIV(HALF), .VERSION_ID(8'h31)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .card_cs(card_cs),
        .flash_cs(flash_cs), .panel_cs(panel_cs), .led_n(led_n),
        .card_detect(card_detect)
    );

    // Mode-0 slave: answer byte on MISO, capture MOSI on rising edges.
    logic [7:0] slave_tx = 8'h00;
    logic [7:0] slave_rx = 8'h00;
    assign spi_miso = slave_tx[7];
    always @(posedge spi_sclk) slave_rx <= {slave_rx[6:0], spi_mosi};
    always @(negedge spi_sclk) slave_tx <= {slave_tx[6:0], 1'b0};

    // Reference model state.
    bit         ref_busy = 1'b0;
    int         ref_k = 0;
    logic [7:0] ref_tx = 8'h00;
    logic [7:0] ref_data = 8'h00;
    logic [7:0] ref_answer = 8'h00;
    logic [3:0] ref_sel = 4'h0;
    logic       ref_cd1 = 1'b0, ref_cd2 = 1'b0;

    // Advance the model on each rising clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_busy = 1'b0; ref_k = 0; ref_data = 8'h00;
            ref_sel = 4'h0; ref_cd1 = 1'b0; ref_cd2 = 1'b0;
        end else begin
            if (ref_busy) begin
                ref_k++;
                if (ref_k == XFER) begin
                    ref_busy = 1'b0;
                    ref_data = ref_answer;
                end
            end else if (bus_wr && bus_addr == 2'd0) begin
                ref_busy = 1'b1; ref_k = 0; ref_tx = bus_wdata;
            end
            if (bus_wr && bus_addr == 2'd1) ref_sel = bus_wdata[3:0];
            ref_cd2 = ref_cd1;
            ref_cd1 = card_detect;
        end
    end

    // Compare pins to the model on every falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            logic exp_sclk;
            exp_sclk = ref_busy && (((ref_k / HALF) % 2) == 1);
            checks++;
            if (spi_sclk !== exp_sclk) begin
                errors++;
                $display("FAIL R3 sclk k=%0d actual=%b expected=%b", ref_k, spi_sclk, exp_sclk);
            end
            if (ref_busy) begin
                checks++;
                if (spi_mosi !== ref_tx[7 - ref_k / (2 * HALF)]) begin
                    errors++;
                    $display("FAIL R2 mosi k=%0d actual=%b expected=%b", ref_k, spi_mosi,
                             ref_tx[7 - ref_k / (2 * HALF)]);
                end
            end
            checks++;
            if ({led_n, panel_cs, flash_cs, card_cs} !== ref_sel) begin
                errors++;
                $display("FAIL R7 select pins actual=%b expected=%b",
                         {led_n, panel_cs, flash_cs, card_cs}, ref_sel);
            end
        end
    end

    task automatic check_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read offset %0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (ref_busy) @(negedge clk);
        @(negedge clk);
    endtask

    // One byte exchange checked at the slave and at the data register.
    task automatic exchange(input logic [7:0] out_b, input logic [7:0] in_b);
        @(negedge clk);
        slave_tx = in_b; ref_answer = in_b;
        bus_write(2'd0, out_b);
        check_read(2'd2, {6'b0, ref_cd2, 1'b1}, "R5 busy during transfer");
        wait_idle();
        check_val(slave_rx, out_b, "R2 byte seen by slave");
        check_read(2'd0, in_b, "R4 received byte");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (spi_sclk !== 1'b0 || card_cs !== 1'b0 || led_n !== 1'b0) begin
            errors++;
            $display("FAIL R1 pins in reset actual=%b%b%b expected=000", spi_sclk, card_cs, led_n);
        end
        rst_n = 1'b1;
        check_read(2'd0, 8'h00, "R1 data reset");
        check_read(2'd1, 8'h00, "R1 select reset");
        check_read(2'd2, 8'h00, "R1 status reset");
        check_read(2'd3, 8'h31, "R9 version");

        exchange(8'hA5, 8'h3C);
        exchange(8'h00, 8'h01);
        exchange(8'hFF, 8'h80);

        // R6: write during a transfer is dropped
        @(negedge clk);
        slave_tx = 8'hC3; ref_answer = 8'hC3;
        bus_write(2'd0, 8'h81);
        repeat (20) @(negedge clk);
        bus_write(2'd0, 8'h00);
        check_read(2'd2, {6'b0, ref_cd2, 1'b1}, "R6 still busy after ignored write");
        wait_idle();
        check_val(slave_rx, 8'h81, "R6 slave byte unchanged");
        check_read(2'd0, 8'hC3, "R6 received byte unchanged");

        // R7: select writes, including during a transfer
        bus_write(2'd1, 8'hFA);
        check_read(2'd1, 8'h0A, "R7 select readback");
        @(negedge clk);
        slave_tx = 8'h5A; ref_answer = 8'h5A;
        bus_write(2'd0, 8'h69);
        repeat (10) @(negedge clk);
        bus_write(2'd1, 8'h05);
        wait_idle();
        check_read(2'd1, 8'h05, "R7 select written mid-transfer");
        check_read(2'd0, 8'h5A, "R4 byte after select write");
        check_read(2'd0, 8'h5A, "R4 byte held");

        // R9: writes to status and version are ignored
        bus_write(2'd3, 8'h55);
        bus_write(2'd2, 8'hFF);
        check_read(2'd3, 8'h31, "R9 version after write");
        check_read(2'd2, 8'h00, "R9 status after write");
        check_read(2'd0, 8'h5A, "R9 data after status write");

        // R8: card detect through two registers
        @(negedge clk);
        card_detect = 1'b1;
        check_read(2'd2, 8'h00, "R8 detect after one clock");
        check_read(2'd2, 8'h02, "R8 detect after two clocks");
        card_detect = 1'b0;
        repeat (3) @(negedge clk);
        check_read(2'd2, 8'h00, "R8 detect cleared");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule